// File: doc/BRIEF.md
# Serial Configuration Register Loader

This block is the configuration front end of an image sensor controller. A host sends address and data over a three-wire synchronous link: a clock, a serial data line and a load strobe. A fourth input selects one of two register banks. Bits are shifted in on rising clock edges. The load strobe then commits the assembled frame on the falling clock edge that follows. The block holds ten 8-bit configuration registers and presents them in parallel to the rest of the controller. It also emits a one-cycle update pulse for each register written.

Two register interlocks are built in. An edge-enable bit in register 1 forces the vertical positive and negative filter nibbles (registers 4 and 5) to fixed values, and it blocks host writes to those nibbles while it is set. A horizontal-filter error flag reports any write of an unsupported horizontal filter pattern to register 6. All registers clear only when both active-low reset inputs are low together.

Top module: `sensor_cfg_loader`

## Requirements
- R1: A frame is 11 bits sent MSB first, made of 3 address bits followed by 8 data bits. Each bit is sampled on a rising `clk` edge while `load` is low. On a rising edge with `load` high, no bit is shifted and the bit count restarts at zero.
- R2: If `load` is high at a falling edge, exactly 11 bits have been shifted since the last restart, and `bank_sel` is 1, the data commits at that falling edge to register N, where N is the address (0 to 7).
- R3: With `bank_sel` 0, address 001 commits to register 8 and address 010 commits to register 9. Every other address in that bank changes no register and raises no update pulse.
- R4: A frame of any length other than 11 bits (for example 10 or 12) is discarded. The next correctly sized frame commits normally.
- R5: When both `rst_logic_n` and `rst_reg_n` are low at a rising edge, every register and `xfilt_err` read 0 from the next falling edge on. Either reset input low on its own leaves the register contents unchanged.
- R6: A commit of register 1 with bit 7 set also writes register 4 bits 3:0 to 0x2 and register 5 bits 3:0 to 0x5. While register 1 bit 7 is 1, writes to registers 4 and 5 change only bits 7:4.
- R7: After register 1 bit 7 is cleared, registers 4 and 5 keep their forced low nibbles until the host writes them, and those nibbles are writable again.
- R8: A commit to register 6 sets `xfilt_err` when bits 3:0 differ from 0001, and clears it when they equal 0001. Other commits leave the flag unchanged.
- R9: Each commit raises `upd[N]`, for register N only, for exactly one clock period (falling edge to falling edge). At all other times `upd` is zero.
- R10: Register contents change only through a commit or the dual reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock: bits are sampled on the rising edge, commits happen on the falling edge |
| rst_logic_n | input | 1 | Active-low logic reset; clears the frame shifter |
| rst_reg_n | input | 1 | Active-low register reset; clears the registers together with rst_logic_n |
| sdata | input | 1 | Serial address/data bit |
| load | input | 1 | Commit strobe; also restarts the bit count |
| bank_sel | input | 1 | 1 selects registers 0 to 7, 0 selects the window registers 8 and 9 |
| cfg_flat | output | 80 | Register N occupies bits 8N+7 down to 8N |
| upd | output | 10 | One-cycle per-register commit pulse |
| xfilt_err | output | 1 | Unsupported horizontal filter pattern was last written |

## Verification
The bench uses the default parameters: 3 address bits, 8 data bits, ten registers, and forced filter values 0x2 and 0x5. With these values every address in both banks, including the illegal addresses in the window bank, can be reached by a short table of frames. The lock sequence is exercised in full: set the edge bit, write while locked, then unlock and rewrite. Frames of 10 and 12 bits check frame alignment. The resets are applied both alone and together.

// File: rtl/sensor_cfg_pkg.sv
package sensor_cfg_pkg;
  localparam int DEF_ADDR_W = 3;
  localparam int DEF_DATA_W = 8;
  localparam int DEF_FILT_W = 4;
  localparam int DEF_WIN_REGS = 2;
  localparam int DEF_EDGE_REG = 1;
  localparam int DEF_EDGE_BIT = 7;
  localparam int DEF_PFILT_REG = 4;
  localparam int DEF_MFILT_REG = 5;
  localparam int DEF_XFILT_REG = 6;
endpackage

// File: rtl/cfg_frame_shifter.sv
module cfg_frame_shifter #(
  parameter int FRAME_W = 11
) (
  input  logic               clk,
  input  logic               clr,
  input  logic               sdata,
  input  logic               load,
  output logic [FRAME_W-1:0] frame,
  output logic               aligned
);
  localparam int CW = $clog2(FRAME_W + 2);
  localparam logic [CW-1:0] FULL = CW'(FRAME_W);
  localparam logic [CW-1:0] OVER = CW'(FRAME_W + 1);

  logic [CW-1:0] cnt;

  // count saturates one past a full frame so longer bursts never look aligned
  always_ff @(posedge clk) begin
    if (clr) begin
      cnt   <= '0;
      frame <= '0;
    end else if (load) begin
      cnt <= '0;
    end else begin
      frame <= {frame[FRAME_W-2:0], sdata};
      if (cnt != OVER) cnt <= cnt + 1'b1;
    end
  end

  assign aligned = (cnt == FULL);
endmodule

// File: rtl/cfg_addr_decode.sv
module cfg_addr_decode #(
  parameter int ADDR_W   = 3,
  parameter int NUM_MAIN = 8,
  parameter int NUM_REGS = 10,
  parameter logic [ADDR_W-1:0] WSTART_ADDR = 3'b001,
  parameter logic [ADDR_W-1:0] WEND_ADDR   = 3'b010
) (
  input  logic                fire,
  input  logic                bank,
  input  logic [ADDR_W-1:0]   addr,
  output logic [NUM_REGS-1:0] sel
);
  for (genvar i = 0; i < NUM_MAIN; i++) begin : g_main
    assign sel[i] = fire & bank & (addr == ADDR_W'(i));
  end

  assign sel[NUM_MAIN]     = fire & ~bank & (addr == WSTART_ADDR);
  assign sel[NUM_MAIN + 1] = fire & ~bank & (addr == WEND_ADDR);
endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank #(
  parameter int DATA_W    = 8,
  parameter int NUM_REGS  = 10,
  parameter int FILT_W    = 4,
  parameter int EDGE_REG  = 1,
  parameter int EDGE_BIT  = 7,
  parameter int PFILT_REG = 4,
  parameter int MFILT_REG = 5,
  parameter int XFILT_REG = 6,
  parameter logic [FILT_W-1:0] P_FORCE  = 4'h2,
  parameter logic [FILT_W-1:0] M_FORCE  = 4'h5,
  parameter logic [FILT_W-1:0] XFILT_OK = 4'b0001
) (
  input  logic                         clk,
  input  logic                         clr,
  input  logic [NUM_REGS-1:0]          sel,
  input  logic [DATA_W-1:0]            wdata,
  output logic [NUM_REGS*DATA_W-1:0]   cfg_flat,
  output logic [NUM_REGS-1:0]          upd,
  output logic                         xfilt_err
);
  logic lock;
  logic edge_set;

  assign lock     = cfg_flat[EDGE_REG*DATA_W + EDGE_BIT];
  assign edge_set = sel[EDGE_REG] & wdata[EDGE_BIT];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    logic [DATA_W-1:0] q;
    if (i == PFILT_REG || i == MFILT_REG) begin : g_filt
      localparam logic [FILT_W-1:0] FV = (i == PFILT_REG) ? P_FORCE : M_FORCE;
      always_ff @(negedge clk) begin
        if (clr) begin
          q <= '0;
        end else begin
          if (sel[i]) q[DATA_W-1:FILT_W] <= wdata[DATA_W-1:FILT_W];
          if (edge_set) q[FILT_W-1:0] <= FV;
          else if (sel[i] && !lock) q[FILT_W-1:0] <= wdata[FILT_W-1:0];
        end
      end
    end else begin : g_plain
      always_ff @(negedge clk) begin
        if (clr) q <= '0;
        else if (sel[i]) q <= wdata;
      end
    end
    assign cfg_flat[i*DATA_W +: DATA_W] = q;
  end

  always_ff @(negedge clk) begin
    if (clr) begin
      upd       <= '0;
      xfilt_err <= 1'b0;
    end else begin
      upd <= sel;
      if (sel[XFILT_REG]) xfilt_err <= (wdata[FILT_W-1:0] != XFILT_OK);
    end
  end
endmodule

// File: rtl/sensor_cfg_loader.sv
module sensor_cfg_loader
  import sensor_cfg_pkg::*;
#(
  parameter int ADDR_W    = DEF_ADDR_W,
  parameter int DATA_W    = DEF_DATA_W,
  parameter int FILT_W    = DEF_FILT_W,
  parameter int EDGE_REG  = DEF_EDGE_REG,
  parameter int EDGE_BIT  = DEF_EDGE_BIT,
  parameter int PFILT_REG = DEF_PFILT_REG,
  parameter int MFILT_REG = DEF_MFILT_REG,
  parameter int XFILT_REG = DEF_XFILT_REG,
  parameter logic [FILT_W-1:0] P_FORCE  = 4'h2,
  parameter logic [FILT_W-1:0] M_FORCE  = 4'h5,
  parameter logic [FILT_W-1:0] XFILT_OK = 4'b0001,
  parameter logic [ADDR_W-1:0] WSTART_ADDR = 3'b001,
  parameter logic [ADDR_W-1:0] WEND_ADDR   = 3'b010
) (
  input  logic                                     clk,
  input  logic                                     rst_logic_n,
  input  logic                                     rst_reg_n,
  input  logic                                     sdata,
  input  logic                                     load,
  input  logic                                     bank_sel,
  output logic [((1<<ADDR_W)+DEF_WIN_REGS)*DATA_W-1:0] cfg_flat,
  output logic [(1<<ADDR_W)+DEF_WIN_REGS-1:0]          upd,
  output logic                                     xfilt_err
);
  localparam int NUM_MAIN = 1 << ADDR_W;
  localparam int NUM_REGS = NUM_MAIN + DEF_WIN_REGS;
  localparam int FRAME_W  = ADDR_W + DATA_W;

  logic               rst_req;
  logic [FRAME_W-1:0] frame;
  logic               aligned;
  logic [NUM_REGS-1:0] sel;

  // dual reset is sampled on the rising edge, acted on at the next falling edge
  always_ff @(posedge clk) rst_req <= ~rst_logic_n & ~rst_reg_n;

  cfg_frame_shifter #(.FRAME_W(FRAME_W)) u_shift (
    .clk     (clk),
    .clr     (~rst_logic_n),
    .sdata   (sdata),
    .load    (load),
    .frame   (frame),
    .aligned (aligned)
  );

  cfg_addr_decode #(
    .ADDR_W(ADDR_W), .NUM_MAIN(NUM_MAIN), .NUM_REGS(NUM_REGS),
    .WSTART_ADDR(WSTART_ADDR), .WEND_ADDR(WEND_ADDR)
  ) u_dec (
    .fire (load & aligned),
    .bank (bank_sel),
    .addr (frame[FRAME_W-1 -: ADDR_W]),
    .sel  (sel)
  );

  cfg_reg_bank #(
    .DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .FILT_W(FILT_W),
    .EDGE_REG(EDGE_REG), .EDGE_BIT(EDGE_BIT),
    .PFILT_REG(PFILT_REG), .MFILT_REG(MFILT_REG), .XFILT_REG(XFILT_REG),
    .P_FORCE(P_FORCE), .M_FORCE(M_FORCE), .XFILT_OK(XFILT_OK)
  ) u_bank (
    .clk       (clk),
    .clr       (rst_req),
    .sel       (sel),
    .wdata     (frame[DATA_W-1:0]),
    .cfg_flat  (cfg_flat),
    .upd       (upd),
    .xfilt_err (xfilt_err)
  );
endmodule

// File: rtl/sensor_cfg_loader_chk.sv
module sensor_cfg_loader_chk #(
  parameter int DATA_W    = 8,
  parameter int NUM_REGS  = 10,
  parameter int FILT_W    = 4,
  parameter int EDGE_REG  = 1,
  parameter int EDGE_BIT  = 7,
  parameter int PFILT_REG = 4,
  parameter int MFILT_REG = 5,
  parameter int XFILT_REG = 6,
  parameter logic [FILT_W-1:0] P_FORCE  = 4'h2,
  parameter logic [FILT_W-1:0] M_FORCE  = 4'h5,
  parameter logic [FILT_W-1:0] XFILT_OK = 4'b0001
) (
  input logic                       clk,
  input logic                       rst_req,
  input logic [NUM_REGS*DATA_W-1:0] cfg_flat,
  input logic [NUM_REGS-1:0]        upd,
  input logic                       xfilt_err
);
  logic seen = 1'b0;
  logic prev_rq = 1'b1;

  always_ff @(posedge clk) begin
    prev_rq <= rst_req;
    if (rst_req) seen <= 1'b1;
  end

  AST_UPD_ONEHOT: assert property (@(posedge clk) disable iff (!seen || rst_req)
    $onehot0(upd)); // R9

  AST_UPD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!seen || rst_req)
    (upd != '0) |=> (upd == '0)); // R9

  AST_HOLD_NO_COMMIT: assert property (@(posedge clk) disable iff (!seen || rst_req)
    (upd == '0 && !prev_rq) |-> $stable(cfg_flat)); // R10

  AST_EDGE_FORCE: assert property (@(posedge clk) disable iff (!seen || rst_req)
    cfg_flat[EDGE_REG*DATA_W + EDGE_BIT] |->
      (cfg_flat[PFILT_REG*DATA_W +: FILT_W] == P_FORCE &&
       cfg_flat[MFILT_REG*DATA_W +: FILT_W] == M_FORCE)); // R6

  AST_XFILT_FLAG: assert property (@(posedge clk) disable iff (!seen || rst_req)
    xfilt_err |-> (cfg_flat[XFILT_REG*DATA_W +: FILT_W] != XFILT_OK)); // R8
endmodule

bind sensor_cfg_loader sensor_cfg_loader_chk #(
  .DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .FILT_W(FILT_W),
  .EDGE_REG(EDGE_REG), .EDGE_BIT(EDGE_BIT),
  .PFILT_REG(PFILT_REG), .MFILT_REG(MFILT_REG), .XFILT_REG(XFILT_REG),
  .P_FORCE(P_FORCE), .M_FORCE(M_FORCE), .XFILT_OK(XFILT_OK)
) u_chk (
  .clk       (clk),
  .rst_req   (rst_req),
  .cfg_flat  (cfg_flat),
  .upd       (upd),
  .xfilt_err (xfilt_err)
);

// File: tb/tb_sensor_cfg_loader.sv
module tb_sensor_cfg_loader;
  logic clk = 1'b0;
  logic rst_logic_n = 1'b0;
  logic rst_reg_n = 1'b0;
  logic sdata = 1'b0;
  logic load = 1'b1;
  logic bank_sel = 1'b1;
  logic [79:0] cfg_flat;
  logic [9:0]  upd;
  logic        xfilt_err;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;
  logic [7:0] model [10];

  always #10 clk = ~clk;

  sensor_cfg_loader dut (
    .clk(clk), .rst_logic_n(rst_logic_n), .rst_reg_n(rst_reg_n),
    .sdata(sdata), .load(load), .bank_sel(bank_sel),
    .cfg_flat(cfg_flat), .upd(upd), .xfilt_err(xfilt_err)
  );

  // vector: bank, addr, data, expected register (15 = none), expected value, expected error flag
  localparam logic [24:0] VEC [18] = '{
    {1'b1, 3'd0, 8'hA5, 4'd0,  8'hA5, 1'b0},  // R2
    {1'b1, 3'd7, 8'h3C, 4'd7,  8'h3C, 1'b0},  // R2
    {1'b1, 3'd3, 8'hFF, 4'd3,  8'hFF, 1'b0},  // R2
    {1'b0, 3'd1, 8'h12, 4'd8,  8'h12, 1'b0},  // R3
    {1'b0, 3'd2, 8'hE7, 4'd9,  8'hE7, 1'b0},  // R3
    {1'b0, 3'd3, 8'h55, 4'd15, 8'h00, 1'b0},  // R3 illegal
    {1'b0, 3'd0, 8'h66, 4'd15, 8'h00, 1'b0},  // R3 illegal
    {1'b0, 3'd7, 8'h77, 4'd15, 8'h00, 1'b0},  // R3 illegal
    {1'b1, 3'd4, 8'h9B, 4'd4,  8'h9B, 1'b0},  // R2
    {1'b1, 3'd5, 8'hC6, 4'd5,  8'hC6, 1'b0},  // R2
    {1'b1, 3'd1, 8'h80, 4'd1,  8'h80, 1'b0},  // R6 force
    {1'b1, 3'd4, 8'h7F, 4'd4,  8'h72, 1'b0},  // R6 locked
    {1'b1, 3'd5, 8'hAA, 4'd5,  8'hA5, 1'b0},  // R6 locked
    {1'b1, 3'd1, 8'h1F, 4'd1,  8'h1F, 1'b0},  // R7 unlock
    {1'b1, 3'd4, 8'h3E, 4'd4,  8'h3E, 1'b0},  // R7 writable
    {1'b1, 3'd6, 8'h51, 4'd6,  8'h51, 1'b0},  // R8 valid
    {1'b1, 3'd6, 8'h53, 4'd6,  8'h53, 1'b1},  // R8 invalid
    {1'b1, 3'd2, 8'h44, 4'd2,  8'h44, 1'b1}   // R8 held
  };

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic chk_all(input string req);
    for (int r = 0; r < 10; r++)
      chk(req, $sformatf("reg%0d", r), {24'd0, cfg_flat[r*8 +: 8]}, {24'd0, model[r]});
  endtask

  // precondition: load high, just after a rising edge
  task automatic send(input logic bank, input logic [11:0] frm, input int n);
    load = 1'b0;
    bank_sel = bank;
    for (int i = n - 1; i >= 0; i--) begin
      sdata = frm[i];
      @(posedge clk); #2;
    end
    load = 1'b1;
    sdata = 1'b0;
    @(posedge clk); #2;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    rst_logic_n = 1'b1;
    rst_reg_n = 1'b1;
    @(posedge clk); #2;
    for (int r = 0; r < 10; r++) model[r] = 8'h00;
    chk_all("R5");
    chk("R9", "upd after reset", {22'd0, upd}, 32'd0);
    chk("R5", "err after reset", {31'd0, xfilt_err}, 32'd0);

    // table walk
    for (int v = 0; v < 18; v++) begin
      logic [24:0] e;
      logic [9:0]  exp_upd;
      e = VEC[v];
      send(e[24], {1'b0, e[23:21], e[20:13]}, 11);
      exp_upd = '0;
      if (e[12:9] != 4'd15) begin
        exp_upd[e[12:9]] = 1'b1;
        model[e[12:9]] = e[8:1];
        if (e[12:9] == 4'd1 && e[8]) begin
          model[4][3:0] = 4'h2;
          model[5][3:0] = 4'h5;
        end
      end
      chk("R1 R2 R3 R9", $sformatf("upd vec%0d", v), {22'd0, upd}, {22'd0, exp_upd});
      chk_all($sformatf("R2 R3 R6 R7 vec%0d", v));
      chk("R8", $sformatf("err vec%0d", v), {31'd0, xfilt_err}, {31'd0, e[0]});
    end

    // R9: pulse gone one clock later
    @(posedge clk); #2;
    chk("R9", "upd width", {22'd0, upd}, 32'd0);

    // R4: short and long frames are dropped
    send(1'b1, {1'b0, 3'd0, 8'h11}, 10);
    chk("R4", "upd short", {22'd0, upd}, 32'd0);
    chk_all("R4 short");
    send(1'b1, {1'b1, 3'd0, 8'h22}, 12);
    chk("R4", "upd long", {22'd0, upd}, 32'd0);
    chk_all("R4 long");
    send(1'b1, {1'b0, 3'd0, 8'h5A}, 11);
    model[0] = 8'h5A;
    chk("R4", "recovery upd", {22'd0, upd}, 32'd1);
    chk_all("R1 R4 recovery");

    // R5: single reset inputs leave contents alone
    rst_reg_n = 1'b0;
    repeat (3) @(posedge clk);
    #2 rst_reg_n = 1'b1;
    @(posedge clk); #2;
    chk_all("R5 reg reset alone");
    rst_logic_n = 1'b0;
    repeat (3) @(posedge clk);
    #2 rst_logic_n = 1'b1;
    @(posedge clk); #2;
    chk_all("R5 logic reset alone");
    chk("R5", "err kept", {31'd0, xfilt_err}, 32'd1);

    // R5: both low clears everything
    rst_logic_n = 1'b0;
    rst_reg_n = 1'b0;
    repeat (2) @(posedge clk);
    #2;
    rst_logic_n = 1'b1;
    rst_reg_n = 1'b1;
    @(posedge clk); #2;
    for (int r = 0; r < 10; r++) model[r] = 8'h00;
    chk_all("R5 dual reset");
    chk("R5", "err cleared", {31'd0, xfilt_err}, 32'd0);

    // R6: edge bit set from zero contents, then locked write to reg5
    send(1'b1, {1'b0, 3'd1, 8'hC3}, 11);
    model[1] = 8'hC3; model[4] = 8'h02; model[5] = 8'h05;
    chk_all("R6 force after reset");
    send(1'b1, {1'b0, 3'd5, 8'hFE}, 11);
    model[5] = 8'hF5;
    chk("R6", "upd locked write", {22'd0, upd}, 32'h20);
    chk_all("R6 locked reg5");

    done = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule